// File: doc/BRIEF.md
# Variable-Count Bit Packing Gearbox

This block sits behind a data recovery stage that hands over a varying number of recovered bits on each clock cycle. Each cycle it takes a 16-bit input vector and a 7-bit count that says how many of the low bits are real. It appends those bits to an internal buffer in the order they arrived. Whenever the buffer holds at least one complete output word, it emits a word of a parameterised width together with a one-cycle valid strobe.

The output width can be wider or narrower than one input chunk. When it is narrower, the buffer keeps a backlog and drains it at one word per cycle. The block has a single clock and no backpressure, so the consumer takes every word that is flagged valid.

Top module: `bit_pack_gearbox`

## Requirements
- R1: Every emitted word is exactly `OUT_W` bits wide, where `OUT_W` may be any value from 2 to 40.
- R2: Only the low `validCnt` bits of `chunkIn` enter the buffer. Bits at or above position `validCnt` are ignored. A count of zero adds nothing.
- R3: The buffered bit total is the bits left over plus `validCnt`. In a cycle where this total reaches `OUT_W` or more, `dataValid` is high in the following cycle.
- R4: In a cycle where the buffered total stays below `OUT_W`, `dataValid` is low in the following cycle.
- R5: Bit ordering is oldest-first at position 0, on both sides. Bit 0 of `chunkIn` is the oldest bit of its chunk, and output bit k is the k-th oldest bit not yet emitted.
- R6: Bits left over after a word is emitted stay in order and become the start of the next word. No bit is lost or duplicated.
- R7: The buffer holds `OUT_W + MAX_CNT - 1` bits. The user keeps the leftover bits plus `validCnt` within that limit.
- R8: While `rst` is high, the buffer empties and `dataValid` goes low. The first word after reset contains only bits presented after reset.
- R9: `dataOut` keeps its last value on every cycle where `dataValid` is low.
- R10: When `OUT_W` is smaller than a chunk, at most one word is emitted per cycle. The backlog then drains one word per cycle, even while counts of zero arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chunkIn | input | IN_W | Recovered bits, oldest at bit 0 |
| validCnt | input | CNT_W | Number of valid low bits in `chunkIn` |
| dataOut | output | OUT_W | Packed output word, oldest bit at bit 0 |
| dataValid | output | 1 | One-cycle strobe for a new word on `dataOut` |

## Verification
The hardest state to reach is a deep backlog in a narrow configuration. In that state the buffer holds far more than one word, and it must drain one word per cycle in order while counts of zero arrive. The bench reaches it with a second instance whose output width is 3. That instance receives a full 16-bit chunk and then a run of empty cycles. Every drained word is compared against a bit queue that models the arrival order. The wide instance walks a table of mixed counts, including zero, full chunks, and junk above the count, so that leftovers wrap across word boundaries.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic emit;  // a full word leaves the buffer this cycle
    logic take;  // the incoming chunk carries at least one bit
  } bpg_strobe_t;
endpackage

// File: rtl/bpg_ctrl.sv
module bpg_ctrl #(
  parameter int OUT_W = 10,
  parameter int CNT_W = 7,
  parameter int LVL_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CNT_W-1:0]        validCnt,
  output bpg_pkg::bpg_strobe_t    strobe,
  output logic [LVL_W-1:0]        fillLevel
);
  localparam int SUM_W = LVL_W + CNT_W;

  logic [SUM_W-1:0] levelSum;
  logic [SUM_W-1:0] levelNext;

  always_comb begin
    levelSum    = SUM_W'(fillLevel) + SUM_W'(validCnt);
    strobe.emit = (levelSum >= SUM_W'(OUT_W));
    strobe.take = (validCnt != '0);
    levelNext   = strobe.emit ? (levelSum - SUM_W'(OUT_W)) : levelSum;
  end

  always_ff @(posedge clk) begin
    if (rst) fillLevel <= '0;
    else     fillLevel <= LVL_W'(levelNext);
  end
endmodule

// File: rtl/bpg_path.sv
module bpg_path #(
  parameter int OUT_W = 10,
  parameter int IN_W  = 16,
  parameter int CNT_W = 7,
  parameter int BUF_W = 25,
  parameter int LVL_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IN_W-1:0]         chunkIn,
  input  logic [CNT_W-1:0]        validCnt,
  input  bpg_pkg::bpg_strobe_t    strobe,
  input  logic [LVL_W-1:0]        fillLevel,
  output logic [OUT_W-1:0]        dataOut,
  output logic                    dataValid
);
  localparam int EXT_W = BUF_W + IN_W;

  logic [BUF_W-1:0] bufReg;
  logic [IN_W-1:0]  chunkMasked;
  logic [EXT_W-1:0] placed;
  logic [EXT_W-1:0] merged;
  logic [BUF_W-1:0] bufNext;

  // keep only the low validCnt bits of the chunk
  genvar g;
  generate
    for (g = 0; g < IN_W; g++) begin : g_mask
      assign chunkMasked[g] = chunkIn[g] & (CNT_W'(g) < validCnt);
    end
  endgenerate

  always_comb begin
    placed  = EXT_W'(chunkMasked) << fillLevel;
    merged  = EXT_W'(bufReg) | placed;
    bufNext = strobe.emit ? BUF_W'(merged >> OUT_W) : BUF_W'(merged);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bufReg    <= '0;
      dataValid <= 1'b0;
      dataOut   <= '0;
    end else begin
      if (strobe.take || strobe.emit) bufReg <= bufNext;
      dataValid <= strobe.emit;
      if (strobe.emit) dataOut <= merged[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/bit_pack_gearbox.sv
module bit_pack_gearbox #(
  parameter int OUT_W   = 10,
  parameter int IN_W    = 16,
  parameter int MAX_CNT = 16,
  parameter int CNT_W   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  chunkIn,
  input  logic [CNT_W-1:0] validCnt,
  output logic [OUT_W-1:0] dataOut,
  output logic             dataValid
);
  localparam int BUF_W = OUT_W + MAX_CNT - 1;
  localparam int LVL_W = $clog2(BUF_W + 1);

  bpg_pkg::bpg_strobe_t strobe;
  logic [LVL_W-1:0]     fillLevel;

  bpg_ctrl #(.OUT_W(OUT_W), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rst(rst), .validCnt(validCnt),
    .strobe(strobe), .fillLevel(fillLevel)
  );

  bpg_path #(.OUT_W(OUT_W), .IN_W(IN_W), .CNT_W(CNT_W),
             .BUF_W(BUF_W), .LVL_W(LVL_W)) u_path (
    .clk(clk), .rst(rst), .chunkIn(chunkIn), .validCnt(validCnt),
    .strobe(strobe), .fillLevel(fillLevel),
    .dataOut(dataOut), .dataValid(dataValid)
  );
endmodule

// File: rtl/bpg_checker.sv
module bpg_checker #(
  parameter int OUT_W = 10,
  parameter int BUF_W = 25,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] validCnt,
  input logic [OUT_W-1:0] dataOut,
  input logic             dataValid
);
  // port-level count of pending bits
  logic [8:0] pend;
  logic [8:0] pendSum;
  assign pendSum = pend + 9'(validCnt);

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pendSum >= 9'(OUT_W)) ? pendSum - 9'(OUT_W) : pendSum;
  end

  p_word_ready_r3: assert property (@(posedge clk) disable iff (rst)
    (pendSum >= 9'(OUT_W)) |=> dataValid);

  p_no_early_word_r4: assert property (@(posedge clk) disable iff (rst)
    (pendSum < 9'(OUT_W)) |=> !dataValid);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    pendSum <= 9'(BUF_W));

  p_reset_idle_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dataValid);

  p_hold_word_r9: assert property (@(posedge clk) disable iff (rst)
    !dataValid && !$past(rst) |-> $stable(dataOut));
endmodule

bind bit_pack_gearbox bpg_checker #(.OUT_W(OUT_W), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .validCnt(validCnt),
  .dataOut(dataOut), .dataValid(dataValid)
);

// File: tb/test_bit_pack_gearbox.sv
module test_bit_pack_gearbox;
  localparam int CLK_PERIOD = 10;
  localparam int WIDE_W = 10;
  localparam int NARROW_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] chunkW = '0, chunkN = '0;
  logic [6:0]  cntW = '0, cntN = '0;
  logic [WIDE_W-1:0]   outW;
  logic [NARROW_W-1:0] outN;
  logic validW, validN;

  int runCount = 0;
  int failCount = 0;
  bit doneFlag = 1'b0;

  bit qW[$];
  bit qN[$];
  logic [WIDE_W-1:0]   lastW = '0;
  logic [NARROW_W-1:0] lastN = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_pack_gearbox #(.OUT_W(WIDE_W)) i_bit_pack_gearbox (
    .clk(clk), .rst(rst), .chunkIn(chunkW), .validCnt(cntW),
    .dataOut(outW), .dataValid(validW));

  bit_pack_gearbox #(.OUT_W(NARROW_W)) i_bit_pack_gearbox_narrow (
    .clk(clk), .rst(rst), .chunkIn(chunkN), .validCnt(cntN),
    .dataOut(outN), .dataValid(validN));

  typedef struct packed {
    logic [15:0] chunk;
    logic [6:0]  cnt;
    logic        expValid;
  } vec_t;

  localparam vec_t TABLE [12] = '{
    '{16'hFFF8, 7'd3,  1'b0},
    '{16'h000A, 7'd4,  1'b0},
    '{16'hA815, 7'd5,  1'b1},
    '{16'hFFFF, 7'd0,  1'b0},
    '{16'h00C3, 7'd8,  1'b1},
    '{16'h9D5B, 7'd16, 1'b1},
    '{16'hFFF6, 7'd4,  1'b1},
    '{16'h0135, 7'd9,  1'b0},
    '{16'h0001, 7'd1,  1'b1},
    '{16'h0002, 7'd2,  1'b0},
    '{16'h7E81, 7'd16, 1'b1},
    '{16'h0003, 7'd2,  1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    runCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle on the wide instance; outputs compared after the edge
  task automatic stepWide(input logic [15:0] ch, input logic [6:0] c, input string req, input bit checkValid, input bit expV);
    logic [WIDE_W-1:0] expWord;
    bit emit;
    cntW = c; chunkW = ch;
    for (int i = 0; i < c; i++) qW.push_back(ch[i]);
    emit = (qW.size() >= WIDE_W);
    expWord = '0;
    if (emit) for (int i = 0; i < WIDE_W; i++) expWord[i] = qW.pop_front();
    @(posedge clk); @(negedge clk);
    cntW = '0; chunkW = '0;
    check(validW == emit, {req, " valid"}, 64'(validW), 64'(emit));
    if (checkValid) check(validW == expV, {req, " table valid"}, 64'(validW), 64'(expV));
    if (emit) begin
      check(outW == expWord, {req, " word"}, 64'(outW), 64'(expWord));
      lastW = expWord;
    end else begin
      check(outW == lastW, "R9 hold", 64'(outW), 64'(lastW));
    end
  endtask

  task automatic stepNarrow(input logic [15:0] ch, input logic [6:0] c, input string req);
    logic [NARROW_W-1:0] expWord;
    bit emit;
    cntN = c; chunkN = ch;
    for (int i = 0; i < c; i++) qN.push_back(ch[i]);
    emit = (qN.size() >= NARROW_W);
    expWord = '0;
    if (emit) for (int i = 0; i < NARROW_W; i++) expWord[i] = qN.pop_front();
    @(posedge clk); @(negedge clk);
    cntN = '0; chunkN = '0;
    check(validN == emit, {req, " narrow valid"}, 64'(validN), 64'(emit));
    if (emit) begin
      check(outN == expWord, {req, " narrow word"}, 64'(outN), 64'(expWord));
      lastN = expWord;
    end else begin
      check(outN == lastN, "R9 narrow hold", 64'(outN), 64'(lastN));
    end
  endtask

  initial begin
    for (int w = 0; w < 2000; w++) @(posedge clk);
    if (!doneFlag) begin
      failCount++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", runCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check(validW == 1'b0, "R8 reset valid", 64'(validW), 0);
    check(outW == '0, "R8 reset word", 64'(outW), 0);
    check(validN == 1'b0, "R8 reset narrow valid", 64'(validN), 0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R6 R9: table walk with junk above the count
    for (int k = 0; k < 12; k++)
      stepWide(TABLE[k].chunk, TABLE[k].cnt, "R3 R4 R5 R6 table", 1'b1, TABLE[k].expValid);

    // R2: zero count with junk ignored
    stepWide(16'hFFFF, 7'd0, "R2 zero count", 1'b0, 1'b0);
    stepWide(16'hFFE5, 7'd5, "R2 junk above count", 1'b0, 1'b0);
    stepWide(16'h0000, 7'd5, "R6 carry", 1'b0, 1'b0);

    // R8: reset mid-stream drops partial bits
    stepWide(16'h001F, 7'd5, "R8 prefill", 1'b0, 1'b0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    qW.delete();
    lastW = '0;
    check(validW == 1'b0, "R8 after reset valid", 64'(validW), 0);
    stepWide(16'h02A5, 7'd10, "R8 fresh word", 1'b0, 1'b0);

    // R10: narrow width backlog, drains one word per cycle
    stepNarrow(16'hB6D3, 7'd16, "R10 full chunk");
    for (int k = 0; k < 6; k++) stepNarrow(16'hFFFF, 7'd0, "R10 drain");
    stepNarrow(16'h0002, 7'd2, "R1 R6 narrow refill");
    stepNarrow(16'h0005, 7'd3, "R5 narrow order");
    stepNarrow(16'h00FF, 7'd7, "R10 partial backlog");
    for (int k = 0; k < 3; k++) stepNarrow(16'h0000, 7'd0, "R10 drain 2");

    doneFlag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end
endmodule